// File: doc/BRIEF.md
# Prescaled Modulus Timer

This block is a free-running up-counter that advances on ticks from a power-of-two clock divider. Its width is a parameter and defaults to 16 bits. Software sets the division, an interrupt enable and a compare-reset enable through one byte-wide control register. When compare reset is enabled, the counter counts from zero up to a supplied compare value and then returns to zero. This turns it into a modulus counter.

When the counter rolls over from all-ones to zero by counting, it sets a sticky overflow flag. Software clears the flag by writing one to it. The interrupt output follows the flag while the interrupt enable is set.

A new division setting does not change the tick pattern mid-period. The divider applies it only at the point where every divider stage is zero. This keeps tick spacing clean across a change.

A global enable input freezes both the divider and the counter.

Top module: `modulus_timer`

## Requirements
- R1: The control register resets to 0x00 and can be read or written at any time. Bit 7 is the interrupt enable, bit 3 is the compare-reset enable, bits 2:0 are the division select, and bits 6:4 always read 0.
- R2: With the enable high and an applied select s, the counter advances by exactly one every 2^s enabled cycles. Select 0 advances every cycle and select 7 advances every 128 cycles.
- R3: The divider is a 7-bit count of enabled cycles since reset. A newly written select takes effect only on a cycle where that count is zero; until then the previous select keeps governing ticks.
- R4: While the enable input is low, neither the divider nor the counter changes.
- R5: With compare reset disabled, a tick at all-ones wraps the counter to zero and sets the overflow flag on the same edge.
- R6: With compare reset enabled, a tick on which the counter equals the compare value loads zero instead of incrementing. The counter therefore holds the compare value for one full tick period and is zero after the next tick.
- R7: With compare reset enabled and a compare value of zero, the counter stays at zero.
- R8: With compare reset enabled and a compare value of all-ones, the return from all-ones to zero never sets the overflow flag.
- R9: A pulse on the clear input clears the overflow flag. If a wrap happens on the same edge, the flag stays set.
- R10: The interrupt output is high exactly when the overflow flag is set and control bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerEn | input | 1 | Global enable for the divider and the counter |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write data |
| ctrlRdata | output | 8 | Control register read value |
| ovfClear | input | 1 | Write-one-to-clear pulse for the overflow flag |
| cmpValue | input | CNT_W | Compare value used for the modulus reset |
| count | output | CNT_W | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same edge: a counting wrap that sets the overflow flag, and a software clear of that flag. The bench runs the counter at division 1 up to all-ones and pulses the clear input on exactly the cycle whose tick causes the wrap. It then judges the flag, and the interrupt with the enable set, as still high afterwards. A second coincidence is a select written while the divider is mid-period. The bench checks that ticks keep the old spacing until the divider count passes zero.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Strobes passed from the control side to the counting datapath.
  typedef struct packed {
    logic tick;   // one enabled prescaler period has elapsed
    logic modEn;  // compare-reset (modulus) mode is active
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int unsigned SEL_W = 3  // select width, at most 3 to fit the register layout
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       timerEn,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  output logic [7:0] ctrlRdata,
  output logic       irqEn,
  output tmrStrobe_t strobes
);
  localparam int unsigned PS_W = (1 << SEL_W) - 1;
  localparam logic [7:0] WR_MASK = 8'h88 | 8'((1 << SEL_W) - 1);

  logic [7:0]       ctrlQ;
  logic [PS_W-1:0]  psCnt;
  logic [SEL_W-1:0] actSel;
  logic [SEL_W-1:0] selNow;
  logic [PS_W:0]    tapAll;

  // Control register: unimplemented bits never store a one.
  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWe) ctrlQ <= ctrlWdata & WR_MASK;
  end

  // Divider stages: a plain binary count of enabled cycles.
  always_ff @(posedge clk) begin
    if (!rstN) psCnt <= '0;
    else if (timerEn) psCnt <= psCnt + PS_W'(1);
  end

  // The requested select is adopted only while all stages read zero.
  assign selNow = (psCnt == '0) ? ctrlQ[SEL_W-1:0] : actSel;

  always_ff @(posedge clk) begin
    if (!rstN) actSel <= '0;
    else actSel <= selNow;
  end

  // tapAll[k] is high when the low k divider stages are all ones.
  assign tapAll[0] = 1'b1;
  for (genvar k = 1; k <= PS_W; k++) begin : gTap
    assign tapAll[k] = tapAll[k-1] & psCnt[k-1];
  end

  assign strobes.tick  = timerEn & tapAll[selNow];
  assign strobes.modEn = ctrlQ[3];
  assign irqEn         = ctrlQ[7];
  assign ctrlRdata     = ctrlQ;
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobes,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic             ovfClear,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] countQ;
  logic             flagQ;
  logic             cmpHit;
  logic             wrapEvt;

  assign cmpHit  = strobes.modEn && (countQ == cmpValue);
  assign wrapEvt = strobes.tick && !cmpHit && (countQ == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else if (strobes.tick) countQ <= cmpHit ? '0 : countQ + CNT_W'(1);
  end

  // Setting outranks a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else if (wrapEvt) flagQ <= 1'b1;
    else if (ovfClear) flagQ <= 1'b0;
  end

  assign count   = countQ;
  assign ovfFlag = flagQ;
endmodule

// File: rtl/modulus_timer.sv
module modulus_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timerEn,
  input  logic             ctrlWe,
  input  logic [7:0]       ctrlWdata,
  output logic [7:0]       ctrlRdata,
  input  logic             ovfClear,
  input  logic [CNT_W-1:0] cmpValue,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             irq
);
  tmrStrobe_t strobes;
  logic       irqEn;

  timer_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .timerEn(timerEn),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .irqEn(irqEn), .strobes(strobes)
  );

  timer_datapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cmpValue(cmpValue), .ovfClear(ovfClear),
    .count(count), .ovfFlag(ovfFlag)
  );

  assign irq = ovfFlag & irqEn;
endmodule

// File: rtl/timer_check.sv
module timer_check #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             timerEn,
  input logic             tick,
  input logic             modEn,
  input logic [CNT_W-1:0] cmpValue,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             ovfClear
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |=> $stable(count));

  assert_still_between_ticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !(modEn && count == cmpValue)) |=> count == CNT_W'($past(count) + 1'b1));

  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !modEn && count == ALL_ONES) |=> (ovfFlag && count == '0));

  assert_modulus_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && modEn && count == cmpValue) |=> count == '0);

  assert_pinned_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && cmpValue == '0 && count == '0) |=> count == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && cmpValue == ALL_ONES && !ovfFlag) |=> !ovfFlag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClear) |=> ovfFlag);
endmodule

bind modulus_timer timer_check #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .timerEn(timerEn),
  .tick(strobes.tick), .modEn(strobes.modEn),
  .cmpValue(cmpValue), .count(count),
  .ovfFlag(ovfFlag), .ovfClear(ovfClear)
);

// File: tb/sim_modulus_timer.sv
module sim_modulus_timer;
  localparam int CW   = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN, en, we, clr;
  logic [7:0]    wd;
  logic [CW-1:0] cmpV;
  logic [7:0]    rdata;
  logic [CW-1:0] cnt;
  logic          flag, irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  // Bench-side expectation state, derived from the requirements.
  int mPs = 0, mAct = 0, mSel = 0, mTcre = 0, mToi = 0, mCnt = 0, mFlag = 0;

  modulus_timer #(.CNT_W(CW), .SEL_W(3)) u0 (
    .clk(clk), .rstN(rstN), .timerEn(en), .ctrlWe(we), .ctrlWdata(wd),
    .ctrlRdata(rdata), .ovfClear(clr), .cmpValue(cmpV), .count(cnt),
    .ovfFlag(flag), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: advance expectations at the edge, compare at the falling edge.
  task automatic step(input string tag);
    int selNow, mask, evt;
    bit tk;
    @(posedge clk);
    selNow = (mPs == 0) ? mSel : mAct;
    mask   = (1 << selNow) - 1;
    tk     = en && ((mPs & mask) == mask);
    mAct   = selNow;
    if (en) mPs = (mPs + 1) % 128;
    evt = 0;
    if (tk) begin
      if (mTcre != 0 && mCnt == int'(cmpV)) mCnt = 0;
      else begin
        if (mCnt == MAXV) evt = 1;
        mCnt = (mCnt + 1) % (MAXV + 1);
      end
    end
    if (evt != 0) mFlag = 1;
    else if (clr) mFlag = 0;
    if (we) begin
      mToi = int'(wd[7]); mTcre = int'(wd[3]); mSel = int'(wd[2:0]);
    end
    @(negedge clk);
    chk(tag, "count", int'(cnt), mCnt);
    chk(tag, "flag", int'(flag), mFlag);
    chk(tag, "irq", int'(irq), mFlag & mToi);
    chk(tag, "ctrl", int'(rdata), (mToi << 7) | (mTcre << 3) | mSel);
    we  = 1'b0;
    clr = 1'b0;
  endtask

  task automatic wrCtrl(input logic [7:0] v, input string tag);
    wd = v; we = 1'b1; step(tag);
  endtask

  initial begin
    int c0, mx, seen, guard;
    rstN = 1'b0; en = 1'b0; we = 1'b0; clr = 1'b0; wd = '0; cmpV = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "reset ctrl", int'(rdata), 0);
    chk("R5", "reset count", int'(cnt), 0);
    chk("R9", "reset flag", int'(flag), 0);
    chk("R10", "reset irq", int'(irq), 0);

    // R1 register layout, unimplemented bits read zero
    wrCtrl(8'hFF, "R1");
    chk("R1", "all-ones write", int'(rdata), 8'h8F);
    wrCtrl(8'h70, "R1");
    chk("R1", "pad bits", int'(rdata), 0);

    // R4 disabled: nothing moves
    repeat (5) step("R4");
    chk("R4", "count idle", int'(cnt), 0);

    // R2 every division
    en = 1'b1;
    for (int s = 0; s < 8; s++) begin
      wrCtrl(8'(s), "R2");
      while (mPs != 0) step("R2");
      c0 = int'(cnt);
      repeat (128) step("R2");
      chk("R2", $sformatf("ticks sel %0d", s), (int'(cnt) - c0) & MAXV, 128 >> s);
    end

    // R3 mid-period select change keeps old spacing
    wrCtrl(8'h00, "R3");
    while (mPs != 0) step("R3");
    while (mPs != 5) step("R3");
    wrCtrl(8'h07, "R3");
    c0 = int'(cnt);
    repeat (20) step("R3");
    chk("R3", "old division kept", (int'(cnt) - c0) & MAXV, 20);
    while (mPs != 0) step("R3");
    c0 = int'(cnt);
    repeat (128) step("R3");
    chk("R3", "new division applied", (int'(cnt) - c0) & MAXV, 1);

    // R4 freeze mid-run
    wrCtrl(8'h00, "R4");
    while (mPs != 0) step("R4");
    repeat (3) step("R4");
    en = 1'b0;
    c0 = int'(cnt);
    repeat (20) step("R4");
    chk("R4", "frozen", int'(cnt), c0);
    en = 1'b1;
    step("R4");
    chk("R4", "resumes", int'(cnt), (c0 + 1) & MAXV);

    // R5 free-running wrap, R10 interrupt gating, R9 clear
    clr = 1'b1; step("R9");
    while (mCnt != MAXV) step("R5");
    step("R5");
    chk("R5", "wrap count", int'(cnt), 0);
    chk("R5", "wrap flag", int'(flag), 1);
    chk("R10", "masked irq", int'(irq), 0);
    wrCtrl(8'h80, "R10");
    chk("R10", "enabled irq", int'(irq), 1);
    clr = 1'b1; step("R9");
    chk("R9", "cleared flag", int'(flag), 0);
    chk("R10", "irq drops", int'(irq), 0);

    // R9 clear colliding with a wrap: set wins
    while (mCnt != MAXV) step("R9");
    clr = 1'b1; step("R9");
    chk("R9", "set beats clear", int'(flag), 1);
    chk("R10", "irq on collision", int'(irq), 1);

    // R6 modulus sweep at division 1
    wrCtrl(8'h08, "R6");
    foreach (cmpListA[i]) begin
      cmpV = CW'(cmpListA[i]);
      clr = 1'b1; step("R6");
      guard = 0;
      while (mCnt != 0 && guard < 600) begin step("R6"); guard++; end
      mx = 0;
      repeat (3 * (cmpListA[i] + 1)) begin
        step("R6");
        if (int'(cnt) > mx) mx = int'(cnt);
      end
      chk("R6", $sformatf("peak for cmp %0d", cmpListA[i]), mx, cmpListA[i]);
      chk("R6", "no overflow in modulus", int'(flag), 0);
    end
    // R6 at division 2: compare value held one full tick period
    cmpV = CW'(3);
    wrCtrl(8'h09, "R6");
    repeat (300) step("R6");

    // R7 compare of zero pins the counter
    wrCtrl(8'h08, "R7");
    cmpV = '0;
    guard = 0;
    while (mCnt != 0 && guard < 600) begin step("R7"); guard++; end
    repeat (50) step("R7");
    chk("R7", "pinned", int'(cnt), 0);

    // R8 compare of all-ones never flags
    cmpV = CW'(MAXV);
    clr = 1'b1; step("R8");
    seen = 0;
    repeat (600) begin
      step("R8");
      if (int'(cnt) == MAXV) seen = 1;
    end
    chk("R8", "reached all-ones", seen, 1);
    chk("R8", "flag stays clear", int'(flag), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  int cmpListA[5] = '{1, 2, 5, 17, 200};

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule